// File: doc/BRIEF.md
# IO Virtual Address Translator

This block turns the addresses that peripheral slots place on a DMA bus into physical memory addresses. It takes one request at a time. Each request carries a slot number, a virtual address and a read/write flag. The block answers with either a physical address or a fault. Translation uses a single-level table of 32-bit entries held in memory and read through a simple memory read port. A small, fully associative cache holds recent translations so that repeated accesses to the same page cost no table read.

The translated window always ends at address 0xFFFFFFFF. A 3-bit range code in the control register sets its size to 16 MB shifted left by the code. Each slot can be set to bypass, in which case its address is treated as physical and a per-slot bit supplies physical bit 30. A register write port sets the control word, the table base and the slot configurations, and carries the two flush commands.

Request, response and table-read traffic use valid/ready handshakes:
- `req_ready` is high only while the block is idle.
- A response stays on `rsp_valid`/`rsp_pa`/`rsp_fault` until `rsp_ready` takes it.
- A table read holds `mem_rd_addr` until `mem_rd_ready` accepts it.
- The returned word arrives later on `mem_rdata_valid`, which has no back-pressure.

Top module: `iova_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_rd_valid` are 0, translation is disabled, every slot is out of bypass and the cache is empty.
- R2: When control bit 0 (enable) is 0 and the slot is not in bypass, the response carries the virtual address unchanged, with no fault and no table read.
- R3: A slot whose configuration bit 0 is set gets physical address {0, cfg bit 1, va[29:0]}, with no fault and no table read, whether or not translation is enabled.
- R4: With translation enabled, range code n in control bits 4:2 defines a window from 2^32 − (16 MB << n) to 0xFFFFFFFF. An address below the window faults with no table read.
- R5: On a cache miss inside the window, exactly one table read is issued, at base + 4 × ((va − window start) >> 12). Its address is held until it is accepted.
- R6: A usable entry yields physical address {0, entry[26:8], va[11:0]}. Entry bit 1 means valid and bit 2 means writable.
- R7: An entry with bit 1 clear faults, and so does a write through an entry with bit 2 clear. A faulting response carries address 0. An invalid entry is never cached.
- R8: A repeated access to a cached page needs no table read. The cache holds 4 pages and replaces in fill order, so a fifth new page evicts the oldest fill.
- R9: Any write to register selector 2 (full flush) invalidates every cached page, whatever the data.
- R10: A write to selector 3 (page flush) invalidates only the cached page whose number equals data[31:12]. Other cached pages still hit.
- R11: Only one request is in flight. `req_ready` is 0 from acceptance until the response is taken, and the response holds stable while `rsp_ready` is 0.
- R12: Register selectors: 0 is control, 1 is table base, 2 is full flush, 3 is page flush, and 4+s is the configuration of slot s. Writes take effect for lookups in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_slot | input | SLOT_W | Requesting slot |
| req_va | input | 32 | Virtual address |
| req_wr | input | 1 | 1 for a write access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation fault |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the table read |
| mem_rd_addr | output | 32 | Table entry address |
| mem_rdata_valid | input | 1 | Table word returned |
| mem_rdata | input | 32 | Table word |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | SEL_W | Register selector |
| reg_wdata | input | 32 | Register write data |

## Verification
The assertions assume that memory returns exactly one word for each accepted table read, and never returns one unasked. They also assume that the control register is not rewritten to disable translation while a table read is pending. The bench's memory model answers each accepted read once, one cycle after acceptance, and can stall `mem_rd_ready` for a set number of cycles. Every register write in the bench is made while the block is idle between requests, so the control word never changes under an outstanding read.

// File: rtl/iova_pkg.sv
package iova_pkg;
  localparam int AW          = 32;
  localparam int PG          = 12;
  localparam int VPN_W       = AW - PG;
  localparam int PPN_W       = 19;
  localparam int WIN_MIN_LOG = 24;

  // table entry fields
  localparam int PTE_V       = 1;
  localparam int PTE_W       = 2;
  localparam int PTE_PPN_LO  = 8;
  localparam int PTE_PPN_HI  = PTE_PPN_LO + PPN_W - 1;

  // register selectors
  localparam int SEL_CTRL    = 0;
  localparam int SEL_BASE    = 1;
  localparam int SEL_FLALL   = 2;
  localparam int SEL_FLPG    = 3;
  localparam int SEL_SLOT0   = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_FETCH,
    S_WAIT,
    S_RESP
  } st_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             wr_ok;
  } map_t;
endpackage

// File: rtl/iova_regs.sv
module iova_regs import iova_pkg::*; #(
  parameter int NSLOT = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [AW-1:0]    wdata,
  output logic             xl_en,
  output logic [2:0]       rng,
  output logic [AW-1:0]    tbl_base,
  output logic [NSLOT-1:0] slot_byp,
  output logic [NSLOT-1:0] slot_hi,
  output logic             flush_all,
  output logic             flush_pg,
  output logic [VPN_W-1:0] flush_vpn
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_en    <= 1'b0;
      rng      <= '0;
      tbl_base <= '0;
    end else if (we) begin
      if (sel == SEL_W'(SEL_CTRL)) begin
        xl_en <= wdata[0];
        rng   <= wdata[4:2];
      end
      if (sel == SEL_W'(SEL_BASE)) tbl_base <= wdata;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_byp[s] <= 1'b0;
        slot_hi[s]  <= 1'b0;
      end else if (we && sel == SEL_W'(SEL_SLOT0 + s)) begin
        slot_byp[s] <= wdata[0];
        slot_hi[s]  <= wdata[1];
      end
    end
  end

  assign flush_all = we && (sel == SEL_W'(SEL_FLALL));
  assign flush_pg  = we && (sel == SEL_W'(SEL_FLPG));
  assign flush_vpn = wdata[AW-1:PG];
endmodule

// File: rtl/iova_pgcalc.sv
module iova_pgcalc import iova_pkg::*; (
  input  logic [AW-1:0] va,
  input  logic [2:0]    rng,
  input  logic [AW-1:0] base,
  output logic          in_win,
  output logic [AW-1:0] pte_addr
);
  logic [4:0]    sz_log;
  logic [AW-1:0] start;
  logic [AW-1:0] offs;

  assign sz_log   = 5'(WIN_MIN_LOG) + {2'b00, rng};
  assign start    = {AW{1'b1}} << sz_log;
  assign in_win   = (va & start) == start;
  assign offs     = va & ~start;
  assign pte_addr = base + ((offs >> PG) << 2);
endmodule

// File: rtl/iova_tlb.sv
module iova_tlb import iova_pkg::*; #(
  parameter int N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output map_t             lk_map,
  input  logic             fill,
  input  logic [VPN_W-1:0] fill_vpn,
  input  map_t             fill_map,
  input  logic             flush_all,
  input  logic             flush_pg,
  input  logic [VPN_W-1:0] flush_vpn
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld;
  logic [VPN_W-1:0] tag [N];
  map_t             ent [N];
  logic [N-1:0]     match;
  logic [IW-1:0]    ptr;
  logic             lk_kill;
  logic             fill_kill;
  logic             fill_do;

  // a flush in the same cycle as a lookup already counts
  assign lk_kill   = flush_all || (flush_pg && flush_vpn == lk_vpn);
  assign fill_kill = flush_all || (flush_pg && flush_vpn == fill_vpn);
  assign fill_do   = fill && !fill_kill;

  for (genvar i = 0; i < N; i++) begin : g_match
    assign match[i] = vld[i] && (tag[i] == lk_vpn);
  end

  always_comb begin
    lk_hit = (|match) && !lk_kill;
    lk_map = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) lk_map = map_t'(lk_map | ent[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush_all || (flush_pg && tag[i] == flush_vpn)) vld[i] <= 1'b0;
      end
      if (fill_do) begin
        vld[ptr] <= 1'b1;
        ptr      <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_do) begin
      tag[ptr] <= fill_vpn;
      ent[ptr] <= fill_map;
    end
  end
endmodule

// File: rtl/iova_fsm.sv
module iova_fsm import iova_pkg::*; #(
  parameter int NSLOT  = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [AW-1:0]     req_va,
  input  logic              req_wr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [AW-1:0]     rsp_pa,
  output logic              rsp_fault,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic              mem_rdata_valid,
  input  logic [AW-1:0]     mem_rdata,
  input  logic              xl_en,
  input  logic [NSLOT-1:0]  slot_byp,
  input  logic [NSLOT-1:0]  slot_hi,
  output logic [AW-1:0]     cur_va,
  input  logic              in_win,
  input  logic [AW-1:0]     pte_addr,
  output logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_hit,
  input  map_t              lk_map,
  output logic              fill,
  output logic [VPN_W-1:0]  fill_vpn,
  output map_t              fill_map
);
  st_t               st, st_n;
  logic [AW-1:0]     va_q, pa_q, pa_n, addr_q;
  logic [SLOT_W-1:0] slot_q;
  logic              wr_q, flt_q, flt_n;
  logic              byp, hi, pte_ok, pte_wr;
  logic              unused_pte;

  assign byp        = slot_byp[slot_q];
  assign hi         = slot_hi[slot_q];
  assign pte_ok     = mem_rdata[PTE_V];
  assign pte_wr     = mem_rdata[PTE_W];
  assign unused_pte = ^{mem_rdata[AW-1:PTE_PPN_HI+1], mem_rdata[PTE_PPN_LO-1:PTE_W+1], mem_rdata[0]};

  assign req_ready    = (st == S_IDLE);
  assign rsp_valid    = (st == S_RESP);
  assign mem_rd_valid = (st == S_FETCH);
  assign mem_rd_addr  = addr_q;
  assign rsp_pa       = pa_q;
  assign rsp_fault    = flt_q;
  assign cur_va       = va_q;
  assign lk_vpn       = va_q[AW-1:PG];

  assign fill         = (st == S_WAIT) && mem_rdata_valid && pte_ok;
  assign fill_vpn     = va_q[AW-1:PG];
  assign fill_map     = '{ppn: mem_rdata[PTE_PPN_HI:PTE_PPN_LO], wr_ok: pte_wr};

  always_comb begin
    st_n  = st;
    pa_n  = pa_q;
    flt_n = flt_q;
    case (st)
      S_IDLE: if (req_valid) st_n = S_LOOK;
      S_LOOK: begin
        st_n  = S_RESP;
        pa_n  = '0;
        flt_n = 1'b0;
        if (byp) begin
          pa_n = {1'b0, hi, va_q[AW-3:0]};
        end else if (!xl_en) begin
          pa_n = va_q;
        end else if (!in_win) begin
          flt_n = 1'b1;
        end else if (lk_hit) begin
          if (wr_q && !lk_map.wr_ok) flt_n = 1'b1;
          else                       pa_n  = {1'b0, lk_map.ppn, va_q[PG-1:0]};
        end else begin
          st_n = S_FETCH;
        end
      end
      S_FETCH: if (mem_rd_ready) st_n = S_WAIT;
      S_WAIT: begin
        if (mem_rdata_valid) begin
          st_n  = S_RESP;
          pa_n  = '0;
          flt_n = 1'b0;
          if (!pte_ok || (wr_q && !pte_wr)) flt_n = 1'b1;
          else pa_n = {1'b0, mem_rdata[PTE_PPN_HI:PTE_PPN_LO], va_q[PG-1:0]};
        end
      end
      S_RESP: if (rsp_ready) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pa_q   <= '0;
      flt_q  <= 1'b0;
      va_q   <= '0;
      wr_q   <= 1'b0;
      slot_q <= '0;
      addr_q <= '0;
    end else begin
      st    <= st_n;
      pa_q  <= pa_n;
      flt_q <= flt_n;
      if (st == S_IDLE && req_valid) begin
        va_q   <= req_va;
        wr_q   <= req_wr;
        slot_q <= req_slot;
      end
      if (st == S_LOOK) addr_q <= pte_addr;
    end
  end
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate import iova_pkg::*; #(
  parameter  int NSLOT  = 4,
  parameter  int TLB_N  = 4,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int SEL_W  = $clog2(SEL_SLOT0 + NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [31:0]       req_va,
  input  logic              req_wr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_pa,
  output logic              rsp_fault,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [31:0]       mem_rd_addr,
  input  logic              mem_rdata_valid,
  input  logic [31:0]       mem_rdata,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [31:0]       reg_wdata
);
  logic             xl_en;
  logic [2:0]       rng;
  logic [AW-1:0]    tbl_base;
  logic [NSLOT-1:0] slot_byp, slot_hi;
  logic             flush_all, flush_pg;
  logic [VPN_W-1:0] flush_vpn;
  logic [AW-1:0]    cur_va, pte_addr;
  logic             in_win;
  logic [VPN_W-1:0] lk_vpn, fill_vpn;
  logic             lk_hit, fill;
  map_t             lk_map, fill_map;

  iova_regs #(.NSLOT(NSLOT), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .xl_en(xl_en), .rng(rng), .tbl_base(tbl_base),
    .slot_byp(slot_byp), .slot_hi(slot_hi),
    .flush_all(flush_all), .flush_pg(flush_pg), .flush_vpn(flush_vpn)
  );

  iova_pgcalc u_calc (
    .va(cur_va), .rng(rng), .base(tbl_base), .in_win(in_win), .pte_addr(pte_addr)
  );

  iova_tlb #(.N(TLB_N)) u_tlb (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_map(lk_map),
    .fill(fill), .fill_vpn(fill_vpn), .fill_map(fill_map),
    .flush_all(flush_all), .flush_pg(flush_pg), .flush_vpn(flush_vpn)
  );

  iova_fsm #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_slot(req_slot),
    .req_va(req_va), .req_wr(req_wr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata),
    .xl_en(xl_en), .slot_byp(slot_byp), .slot_hi(slot_hi),
    .cur_va(cur_va), .in_win(in_win), .pte_addr(pte_addr),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_map(lk_map),
    .fill(fill), .fill_vpn(fill_vpn), .fill_map(fill_map)
  );
endmodule

// File: rtl/iova_xlate_chk.sv
module iova_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_pa,
  input logic        rsp_fault,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        xl_en
);
  p_single_flight_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault));

  p_memreq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  p_fetch_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> xl_en);

  p_fault_zero_pa_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == 32'h0);

  p_no_rsp_in_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !rsp_valid && !req_ready);
endmodule

bind iova_xlate iova_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .xl_en(xl_en)
);

// File: tb/iova_xlate_bench.sv
module iova_xlate_bench;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_wr, rsp_ready;
  logic [1:0]  req_slot;
  logic [31:0] req_va;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [31:0] rsp_pa;
  logic        mem_rd_valid, mem_rd_ready, mem_rdata_valid;
  logic [31:0] mem_rd_addr, mem_rdata;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;

  int          n_chk = 0, n_bad = 0;
  int          fetch_cnt = 0, stall_left = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] pte_mem [256];
  logic        pend = 1'b0;
  logic [31:0] pend_addr;
  logic [31:0] got_pa;
  logic        got_flt;

  always #4 clk = ~clk;

  iova_xlate u_iova_xlate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_slot(req_slot),
    .req_va(req_va), .req_wr(req_wr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata)
  );

  function automatic logic [18:0] ppn_of(input int i);
    return 19'(32'h2_0000 + i * 3);
  endfunction

  function automatic logic [31:0] mk_pte(input int i, input logic wr, input logic v);
    return ({13'b0, ppn_of(i)} << 8) | ({29'b0, wr, 2'b0}) | ({30'b0, v, 1'b0});
  endfunction

  function automatic logic [31:0] exp_pa(input int i, input logic [31:0] va);
    return {1'b0, ppn_of(i), va[11:0]};
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    logic [31:0] idx;
    idx = (a - BASE) >> 2;
    if (a >= BASE && idx < 256) return pte_mem[idx];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: one word per accepted read, one cycle later
  initial begin
    mem_rdata_valid = 1'b0;
    mem_rdata       = '0;
    mem_rd_ready    = 1'b1;
    forever begin
      @(negedge clk);
      mem_rdata_valid = 1'b0;
      if (pend) begin
        mem_rdata_valid = 1'b1;
        mem_rdata       = rd_word(pend_addr);
        pend            = 1'b0;
      end else begin
        mem_rd_ready = (stall_left == 0);
        if (mem_rd_valid && stall_left > 0) stall_left--;
        else if (mem_rd_valid && mem_rd_ready) begin
          pend      = 1'b1;
          pend_addr = mem_rd_addr;
          last_addr = mem_rd_addr;
          fetch_cnt++;
        end
      end
    end
  end

  task automatic reg_wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic xlate(input int slot, input logic [31:0] va, input logic wr, input int hold);
    int n;
    logic [31:0] pa0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 idle ready", {31'b0, req_ready}, 32'h1);
    req_slot = 2'(slot); req_va = va; req_wr = wr; req_valid = 1'b1;
    rsp_ready = (hold == 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 busy not ready", {31'b0, req_ready}, 32'h0);
    n = 0;
    while (!rsp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, "R11 response arrives", {31'b0, rsp_valid}, 32'h1);
    got_pa  = rsp_pa;
    got_flt = rsp_fault;
    pa0     = rsp_pa;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pa == pa0 && !req_ready, "R11 response held", rsp_pa, pa0);
    end
    rsp_ready = 1'b1;
  endtask

  task automatic xl_chk(input string tag, input int slot, input logic [31:0] va, input logic wr,
                        input logic eflt, input logic [31:0] epa, input int efetch);
    int f0;
    f0 = fetch_cnt;
    xlate(slot, va, wr, 0);
    chk(got_flt == eflt, {tag, " fault"}, {31'b0, got_flt}, {31'b0, eflt});
    chk(got_pa == epa, {tag, " address"}, got_pa, epa);
    chk(fetch_cnt - f0 == efetch, {tag, " table reads"}, 32'(fetch_cnt - f0), 32'(efetch));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid", {31'b0, mem_rd_valid}, 32'h0);
    xl_chk("R1 disabled after reset", 3, 32'hFF00_1234, 1'b0, 1'b0, 32'hFF00_1234, 0);
  endtask

  task automatic t_passthrough();
    xl_chk("R2 passthrough read", 0, 32'h1234_5678, 1'b0, 1'b0, 32'h1234_5678, 0);
    xl_chk("R2 passthrough write", 2, 32'hFFFF_F000, 1'b1, 1'b0, 32'hFFFF_F000, 0);
  endtask

  task automatic t_bypass();
    reg_wr(5, 32'h3);            // R12 slot 1: bypass, high bit set
    reg_wr(6, 32'h1);            // slot 2: bypass, high bit clear
    reg_wr(0, 32'h1);            // enable, range code 0
    reg_wr(1, BASE);
    xl_chk("R3 bypass hi", 1, 32'hC000_0ABC, 1'b1, 1'b0, 32'h4000_0ABC, 0);
    xl_chk("R3 bypass lo", 2, 32'hFFFF_1234, 1'b0, 1'b0, 32'h3FFF_1234, 0);
  endtask

  task automatic t_window();
    xl_chk("R4 below 16MB window", 0, 32'hFEFF_FFFF, 1'b0, 1'b1, 32'h0, 0);
    xl_chk("R5 R6 first entry", 0, 32'hFF00_0123, 1'b0, 1'b0, exp_pa(0, 32'hFF00_0123), 1);
    chk(last_addr == BASE, "R5 entry address code0", last_addr, BASE);
    reg_wr(0, 32'h1 | (32'd1 << 2));
    xl_chk("R5 R6 32MB window", 0, 32'hFE00_3456, 1'b0, 1'b0, exp_pa(3, 32'hFE00_3456), 1);
    chk(last_addr == BASE + 12, "R5 entry address code1", last_addr, BASE + 12);
    reg_wr(0, 32'h1 | (32'd7 << 2));
    xl_chk("R4 below 2GB window", 0, 32'h7FFF_FFFF, 1'b0, 1'b1, 32'h0, 0);
    stall_left = 3;
    xl_chk("R5 R6 2GB window stalled", 0, 32'h8000_5FFF, 1'b1, 1'b0, exp_pa(5, 32'h8000_5FFF), 1);
    chk(last_addr == BASE + 20, "R5 entry address code7", last_addr, BASE + 20);
    reg_wr(0, 32'h1);
  endtask

  task automatic t_perm();
    xl_chk("R7 write to read-only", 0, 32'hFF00_8010, 1'b1, 1'b1, 32'h0, 1);
    xl_chk("R8 read hit read-only", 0, 32'hFF00_8020, 1'b0, 1'b0, exp_pa(8, 32'hFF00_8020), 0);
    xl_chk("R7 write hit read-only", 0, 32'hFF00_8030, 1'b1, 1'b1, 32'h0, 0);
    xl_chk("R7 invalid entry", 0, 32'hFF00_9000, 1'b0, 1'b1, 32'h0, 1);
    xl_chk("R7 invalid not cached", 0, 32'hFF00_9004, 1'b0, 1'b1, 32'h0, 1);
  endtask

  task automatic t_cache();
    reg_wr(2, 32'hDEAD_BEEF);
    xl_chk("R9 flushed page refetched", 0, 32'hFF00_8040, 1'b0, 1'b0, exp_pa(8, 32'hFF00_8040), 1);
    for (int p = 16; p < 20; p++)
      xl_chk("R8 fill", 0, 32'hFF00_0000 | (32'(p) << 12), 1'b0, 1'b0, exp_pa(p, 32'hFF00_0000 | (32'(p) << 12)), 1);
    for (int p = 16; p < 20; p++)
      xl_chk("R8 hit", 0, 32'hFF00_0008 | (32'(p) << 12), 1'b0, 1'b0, exp_pa(p, 32'hFF00_0008 | (32'(p) << 12)), 0);
    xl_chk("R8 fifth page", 0, 32'hFF01_4000, 1'b0, 1'b0, exp_pa(20, 32'hFF01_4000), 1);
    xl_chk("R8 second fill kept", 0, 32'hFF01_1000, 1'b0, 1'b0, exp_pa(17, 32'hFF01_1000), 0);
    xl_chk("R8 oldest evicted", 0, 32'hFF01_0000, 1'b0, 1'b0, exp_pa(16, 32'hFF01_0000), 1);
    xl_chk("R8 next oldest evicted", 0, 32'hFF01_1000, 1'b0, 1'b0, exp_pa(17, 32'hFF01_1000), 1);
  endtask

  task automatic t_page_flush();
    reg_wr(3, 32'hFF01_0ABC);
    xl_chk("R10 other page kept", 0, 32'hFF01_3000, 1'b0, 1'b0, exp_pa(19, 32'hFF01_3000), 0);
    xl_chk("R10 other page kept b", 0, 32'hFF01_4000, 1'b0, 1'b0, exp_pa(20, 32'hFF01_4000), 0);
    xl_chk("R10 flushed page refetched", 0, 32'hFF01_0000, 1'b0, 1'b0, exp_pa(16, 32'hFF01_0000), 1);
  endtask

  task automatic t_backpressure();
    xlate(0, 32'hFF01_0444, 1'b0, 4);
    chk(got_pa == exp_pa(16, 32'hFF01_0444), "R11 held address", got_pa, exp_pa(16, 32'hFF01_0444));
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) pte_mem[i] = mk_pte(i, 1'b1, 1'b1);
    pte_mem[8] = mk_pte(8, 1'b0, 1'b1);
    pte_mem[9] = mk_pte(9, 1'b1, 1'b0);
    rst_n = 1'b0;
    req_valid = 1'b0; req_wr = 1'b0; req_slot = '0; req_va = '0; rsp_ready = 1'b1;
    reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_passthrough();
    t_bypass();
    t_window();
    t_perm();
    t_cache();
    t_page_flush();
    t_backpressure();
    finish_run();
  end
endmodule